// File: doc/BRIEF.md
# Ordered Multi-Domain Reset Sequencer

This block sits in the control clock domain and owns the resets of three clock domains: the destination (data sink), the source (data producer) and the request/control domain. It runs one fixed sequence. It runs once at power-up, driven by the control reset input. It runs again whenever the surrounding logic asks for a shutdown after an aborted transfer has drained its outstanding transactions and gone idle. The reset clears all stale state at once, so no pipeline is flushed sample by sample.

In every domain, reset is raised at once through the preset of a short synchronizer chain, with no wait for a clock edge in that domain. Each domain counts its own clock edges while it is held in reset. The sequencer keeps all three domains held until every domain has reported a full hold, so the slowest clock sets the length. The sequencer then frees the domains against the direction of data flow. The destination goes first, then the source, then the request domain. Each release waits until the reset of the domain before it has been seen to drop. A ready flag and per-domain enables come up only after the last release. Pause drops the enables of the two data domains without any reset, so those domains carry on from where they stopped when the pause is removed.

Top module: `rst_order_seq`

## Requirements
- R1: While `rst_n` is low, all three bits of `dom_rst` are high, `ready` is low and `dom_en` is 3'b000.
- R2: Every domain reset stays high for at least HOLD_CYC full periods of the slowest domain clock, both at power-up and on a shutdown.
- R3: Reset release order is fixed by bit position: `dom_rst[0]` (destination) falls first, then `dom_rst[1]` (source), then `dom_rst[2]` (request). No bit falls while a lower-numbered bit is still high.
- R4: `ready` rises only after all three `dom_rst` bits have fallen, and it stays high until a shutdown is accepted.
- R5: A one-cycle `shutdown_req` while `ready` is high raises all three `dom_rst` bits before the next falling control edge and drops `ready`. The whole hold-and-release sequence then runs again.
- R6: `shutdown_req` is ignored while a sequence is in progress. Once `ready` returns, no further sequence starts.
- R7: With `pause` high while ready, `dom_en` becomes 3'b100 one control cycle later: destination and source are disabled and request stays enabled. `dom_rst` and `ready` are not affected.
- R8: Lowering `pause` restores `dom_en` to 3'b111 one control cycle later, with no reset of any domain.
- R9: `dom_en` is 3'b000 whenever `ready` is low. It takes its enabled value in the same cycle that `ready` rises: 3'b111 without pause, 3'b100 with pause held.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Control clock; the sequencer state machine runs on it |
| rst_n | input | 1 | Synchronous active-low power-up reset; forces a full sequence |
| dom_clk | input | 3 | Domain clocks: bit 0 destination, bit 1 source, bit 2 request |
| shutdown_req | input | 1 | Request to reset all domains after an abort has gone idle; accepted only while ready |
| pause | input | 1 | Disables the destination and source domains while high |
| dom_rst | output | 3 | Active-high domain resets, each released in its own clock domain |
| dom_en | output | 3 | Domain enables, same bit order as `dom_rst` |
| ready | output | 1 | High once every domain has been released and the sequence is finished |

## Verification
The bench builds the block with its defaults: HOLD_CYC = 4, SYNC_STAGES = 4 and ACK_STAGES = 2. The control clock runs at 200 MHz. The domain clocks are unrelated: 9 ns for the destination, 23 ns for the source and 6 ns for the request domain. The slowest domain is therefore the one released in the middle, so a hold time taken from the control clock, or from the first domain to be freed, would come out visibly short of 92 ns. The ack-gated release order and the pause and shutdown edges can each be seen at the ports.

// File: rtl/ors_pkg.sv
`timescale 1ns / 1ps
// ors_pkg: shared constants and the sequencer state type.
// Domain bit positions encode the release order: lower index released first.
package ors_pkg;

    localparam int NUM_DOM  = 3;
    localparam int DOM_DEST = 0;
    localparam int DOM_SRC  = 1;
    localparam int DOM_REQ  = 2;

    typedef enum logic [2:0] {
        ST_IDLE          = 3'd0,
        ST_DO_RESET      = 3'd1,
        ST_WAIT_ASSERTED = 3'd2,
        ST_RELEASE_DEST  = 3'd3,
        ST_RELEASE_SRC   = 3'd4,
        ST_RELEASE_REQ   = 3'd5,
        ST_DONE          = 3'd6
    } seq_state_t;

endpackage

// File: rtl/ors_sync_chain.sv
`timescale 1ns / 1ps
// ors_sync_chain: reset synchronizer for one domain.
// Assumes: preset comes from a control-domain flop. The chain is forced high
// asynchronously by preset and shifts zeros in on its own clock once preset
// drops, so release is aligned to the domain clock after STAGES edges.
// The asynchronous preset is deliberate here: assertion must not need a clock.
module ors_sync_chain #(
    parameter int STAGES = 4
) (
    input  logic clk,
    input  logic preset,
    output logic rst_out
);

    logic [STAGES-1:0] stage_q;

    // Set all stages on preset, otherwise shift a zero towards the output.
    always_ff @(posedge clk or posedge preset) begin
        if (preset) begin
            stage_q <= '1;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], 1'b0};
        end
    end

    assign rst_out = stage_q[STAGES-1];

endmodule

// File: rtl/ors_hold_meter.sv
`timescale 1ns / 1ps
// ors_hold_meter: counts domain clock edges seen with the domain reset high.
// Assumes: clr is high from the control domain whenever no hold is being
// measured; it clears the count asynchronously so a stale count never leaks
// into a new sequence. held rises after HOLD_EDGES edges in reset.
module ors_hold_meter #(
    parameter int HOLD_EDGES = 5
) (
    input  logic clk,
    input  logic clr,
    input  logic rst_in,
    output logic held
);

    localparam int CW = $clog2(HOLD_EDGES + 1);
    localparam logic [CW-1:0] CNT_MAX = CW'(HOLD_EDGES);

    logic [CW-1:0] cnt_q;

    // Saturating edge counter, enabled while the domain reset is high.
    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            cnt_q <= '0;
        end else if (rst_in && (cnt_q != CNT_MAX)) begin
            cnt_q <= cnt_q + 1'b1;
        end
    end

    assign held = (cnt_q == CNT_MAX);

endmodule

// File: rtl/ors_bit_sync.sv
`timescale 1ns / 1ps
// ors_bit_sync: multi-flop synchronizer of a slow level into the control clock.
// Assumes: d changes far slower than clk; reset value chosen by RST_VAL.
module ors_bit_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b0
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d,
    output logic q
);

    logic [STAGES-1:0] sync_q;

    // Shift the incoming level through the chain; synchronous active-low reset.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sync_q <= {STAGES{RST_VAL}};
        end else begin
            sync_q <= {sync_q[STAGES-2:0], d};
        end
    end

    assign q = sync_q[STAGES-1];

endmodule

// File: rtl/ors_fsm.sv
`timescale 1ns / 1ps
// ors_fsm: control-domain state machine of the reset sequencer.
// Assumes: ack[d] is the synchronized level of domain d's reset and held[d]
// the synchronized hold-complete flag. All domains are asserted together.
// Release runs destination, source, request, each gated by the previous ack.
module ors_fsm
    import ors_pkg::*;
(
    input  logic               clk,
    input  logic               rst_n,
    input  logic               shutdown_req,
    input  logic               pause,
    input  logic [NUM_DOM-1:0] ack,
    input  logic [NUM_DOM-1:0] held,
    output logic [NUM_DOM-1:0] rst_req,
    output logic               hold_clr,
    output logic [NUM_DOM-1:0] dom_en,
    output logic               ready
);

    seq_state_t         state_q, state_d;
    logic [NUM_DOM-1:0] rst_req_q, rst_req_d;
    logic               hold_clr_q, hold_clr_d;
    logic [NUM_DOM-1:0] en_q, en_d;

    // Next-state and next-output decode for the sequence.
    always_comb begin
        state_d    = state_q;
        rst_req_d  = rst_req_q;
        hold_clr_d = hold_clr_q;
        unique case (state_q)
            ST_IDLE: begin
                hold_clr_d = 1'b1;
                if (shutdown_req) begin
                    state_d   = ST_DO_RESET;
                    rst_req_d = '1;
                end
            end
            ST_DO_RESET: begin
                hold_clr_d = 1'b0;
                if (&ack) begin
                    state_d = ST_WAIT_ASSERTED;
                end
            end
            ST_WAIT_ASSERTED: begin
                if (&held) begin
                    state_d             = ST_RELEASE_DEST;
                    rst_req_d[DOM_DEST] = 1'b0;
                    hold_clr_d          = 1'b1;
                end
            end
            ST_RELEASE_DEST: begin
                if (!ack[DOM_DEST]) begin
                    state_d            = ST_RELEASE_SRC;
                    rst_req_d[DOM_SRC] = 1'b0;
                end
            end
            ST_RELEASE_SRC: begin
                if (!ack[DOM_SRC]) begin
                    state_d            = ST_RELEASE_REQ;
                    rst_req_d[DOM_REQ] = 1'b0;
                end
            end
            ST_RELEASE_REQ: begin
                if (!ack[DOM_REQ]) begin
                    state_d = ST_DONE;
                end
            end
            ST_DONE: begin
                if (held == '0) begin
                    state_d = ST_IDLE;
                end
            end
            default: begin
                state_d    = ST_DO_RESET;
                rst_req_d  = '1;
                hold_clr_d = 1'b1;
            end
        endcase
    end

    // Enables follow the next state so they drop in the cycle a shutdown starts.
    always_comb begin
        en_d = '0;
        if (state_d == ST_IDLE) begin
            en_d[DOM_REQ]  = 1'b1;
            en_d[DOM_SRC]  = !pause;
            en_d[DOM_DEST] = !pause;
        end
    end

    // State and output registers; power-up reset forces a fresh sequence.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_DO_RESET;
            rst_req_q  <= '1;
            hold_clr_q <= 1'b1;
            en_q       <= '0;
        end else begin
            state_q    <= state_d;
            rst_req_q  <= rst_req_d;
            hold_clr_q <= hold_clr_d;
            en_q       <= en_d;
        end
    end

    assign rst_req  = rst_req_q;
    assign hold_clr = hold_clr_q;
    assign dom_en   = en_q;
    assign ready    = (state_q == ST_IDLE);

endmodule

// File: rtl/rst_order_seq.sv
`timescale 1ns / 1ps
// rst_order_seq: ordered reset sequencer for destination, source and request
// clock domains. Assumes dom_clk bits run freely and are unrelated to clk.
// Per domain: a preset synchronizer produces the reset, a hold meter counts
// that domain's edges in reset, and both levels are synchronized back.
module rst_order_seq
    import ors_pkg::*;
#(
    parameter int SYNC_STAGES = 4,
    parameter int HOLD_CYC    = 4,
    parameter int ACK_STAGES  = 2
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_DOM-1:0] dom_clk,
    input  logic               shutdown_req,
    input  logic               pause,
    output logic [NUM_DOM-1:0] dom_rst,
    output logic [NUM_DOM-1:0] dom_en,
    output logic               ready
);

    // One more edge than full periods, so HOLD_CYC whole periods are covered.
    localparam int HOLD_EDGES = HOLD_CYC + 1;

    logic [NUM_DOM-1:0] rst_req;
    logic               hold_clr;
    logic [NUM_DOM-1:0] held_dom;
    logic [NUM_DOM-1:0] ack;
    logic [NUM_DOM-1:0] held;

    for (genvar d = 0; d < NUM_DOM; d++) begin : g_dom
        ors_sync_chain #(
            .STAGES (SYNC_STAGES)
        ) u_chain (
            .clk     (dom_clk[d]),
            .preset  (rst_req[d]),
            .rst_out (dom_rst[d])
        );

        ors_hold_meter #(
            .HOLD_EDGES (HOLD_EDGES)
        ) u_meter (
            .clk    (dom_clk[d]),
            .clr    (hold_clr),
            .rst_in (dom_rst[d]),
            .held   (held_dom[d])
        );

        ors_bit_sync #(
            .STAGES  (ACK_STAGES),
            .RST_VAL (1'b1)
        ) u_ack_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (dom_rst[d]),
            .q     (ack[d])
        );

        ors_bit_sync #(
            .STAGES  (ACK_STAGES),
            .RST_VAL (1'b0)
        ) u_held_sync (
            .clk   (clk),
            .rst_n (rst_n),
            .d     (held_dom[d]),
            .q     (held[d])
        );
    end

    ors_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .shutdown_req (shutdown_req),
        .pause        (pause),
        .ack          (ack),
        .held         (held),
        .rst_req      (rst_req),
        .hold_clr     (hold_clr),
        .dom_en       (dom_en),
        .ready        (ready)
    );

endmodule

// File: rtl/rst_order_seq_chk.sv
`timescale 1ns / 1ps
// rst_order_seq_chk: port-level properties of the reset sequencer, sampled on
// the control clock. Bound to every rst_order_seq instance below.
module rst_order_seq_chk
    import ors_pkg::*;
(
    input logic               clk,
    input logic               rst_n,
    input logic               shutdown_req,
    input logic               pause,
    input logic [NUM_DOM-1:0] dom_rst,
    input logic [NUM_DOM-1:0] dom_en,
    input logic               ready
);

    // R4: ready implies every domain is out of reset.
    a_r4_ready_all_released: assert property (@(posedge clk) disable iff (!rst_n)
        ready |-> (dom_rst == '0));

    // R4: ready persists while no shutdown is requested.
    a_r4_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
        (ready && !shutdown_req) |=> ready);

    // R3: source leaves reset only after destination has.
    a_r3_src_after_dest: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_rst[DOM_SRC]) |-> !dom_rst[DOM_DEST]);

    // R3: request leaves reset only after both data domains have.
    a_r3_req_after_data: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(dom_rst[DOM_REQ]) |-> (!dom_rst[DOM_SRC] && !dom_rst[DOM_DEST]));

    // R9: no enable while the sequencer is not ready.
    a_r9_en_needs_ready: assert property (@(posedge clk) disable iff (!rst_n)
        (|dom_en) |-> ready);

    // R9: an enabled domain is never in reset.
    a_r9_en_out_of_reset: assert property (@(posedge clk) disable iff (!rst_n)
        (|dom_en) |-> (dom_rst == '0));

    // R7: pause seen on the previous edge keeps both data domains disabled.
    a_r7_pause_disables: assert property (@(posedge clk) disable iff (!rst_n)
        $past(pause) |-> (!dom_en[DOM_DEST] && !dom_en[DOM_SRC]));

endmodule

bind rst_order_seq rst_order_seq_chk u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .shutdown_req (shutdown_req),
    .pause        (pause),
    .dom_rst      (dom_rst),
    .dom_en       (dom_en),
    .ready        (ready)
);

// File: tb/rst_order_seq_tb.sv
`timescale 1ns / 1ps
// rst_order_seq_tb: directed tests, one task per scenario.
module rst_order_seq_tb;

    localparam realtime SLOW_T   = 23.0;
    localparam int      HOLD_CYC = 4;
    localparam realtime MIN_HOLD = SLOW_T * HOLD_CYC;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [2:0] dom_clk = 3'b000;
    logic       shutdown_req = 1'b0;
    logic       pause = 1'b0;
    logic [2:0] dom_rst;
    logic [2:0] dom_en;
    logic       ready;

    int checks = 0;
    int fails  = 0;

    realtime t_rise [3];
    realtime t_fall [3];
    realtime t_ready;

    rst_order_seq #(
        .SYNC_STAGES (4),
        .HOLD_CYC    (HOLD_CYC),
        .ACK_STAGES  (2)
    ) u_dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .dom_clk      (dom_clk),
        .shutdown_req (shutdown_req),
        .pause        (pause),
        .dom_rst      (dom_rst),
        .dom_en       (dom_en),
        .ready        (ready)
    );

    always #2.5  clk = ~clk;
    always #4.5  dom_clk[0] = ~dom_clk[0];
    always #11.5 dom_clk[1] = ~dom_clk[1];
    always #3.0  dom_clk[2] = ~dom_clk[2];

    always @(posedge dom_rst[0]) t_rise[0] = $realtime;
    always @(posedge dom_rst[1]) t_rise[1] = $realtime;
    always @(posedge dom_rst[2]) t_rise[2] = $realtime;
    always @(negedge dom_rst[0]) t_fall[0] = $realtime;
    always @(negedge dom_rst[1]) t_fall[1] = $realtime;
    always @(negedge dom_rst[2]) t_fall[2] = $realtime;
    always @(posedge ready)      t_ready   = $realtime;

    task automatic check(input bit ok, input string tag, input string act, input string exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%s expected=%s", tag, act, exp);
        end
    endtask

    task automatic check_bits(input string tag, input logic [31:0] act, input logic [31:0] exp);
        check(act === exp, tag, $sformatf("%0h", act), $sformatf("%0h", exp));
    endtask

    task automatic wait_ready(input string tag);
        int n = 0;
        while (ready !== 1'b1 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        check(ready === 1'b1, tag, "ready timeout", "ready high");
    endtask

    // R2, R3, R4: durations and release order of the last sequence.
    task automatic check_sequence(input string tag);
        for (int d = 0; d < 3; d++) begin
            check((t_fall[d] - t_rise[d]) >= MIN_HOLD, {tag, " R2 hold"},
                  $sformatf("%0t", t_fall[d] - t_rise[d]), $sformatf(">=%0t", MIN_HOLD));
        end
        check((t_fall[0] < t_fall[1]) && (t_fall[1] < t_fall[2]), {tag, " R3 order"},
              $sformatf("%0t/%0t/%0t", t_fall[0], t_fall[1], t_fall[2]), "dest<src<req");
        check(t_fall[2] <= t_ready, {tag, " R4 ready after release"},
              $sformatf("%0t", t_ready), $sformatf(">=%0t", t_fall[2]));
    endtask

    task automatic t_powerup();
        repeat (6) @(negedge clk);
        check_bits("R1 dom_rst in reset", 32'(dom_rst), 32'h7);
        check_bits("R1 ready in reset", 32'(ready), 32'h0);
        check_bits("R1 dom_en in reset", 32'(dom_en), 32'h0);
        rst_n = 1'b1;
        @(negedge clk);
        check_bits("R9 no enable before ready", 32'(dom_en), 32'h0);
        wait_ready("R4 powerup");
        check_bits("R9 enables with ready", 32'(dom_en), 32'h7);
        check_bits("R4 all released", 32'(dom_rst), 32'h0);
        check_sequence("powerup");
    endtask

    task automatic t_pause();
        pause = 1'b1;
        @(negedge clk);
        check_bits("R7 pause enables", 32'(dom_en), 32'h4);
        repeat (8) @(negedge clk);
        check_bits("R7 pause no reset", 32'({ready, dom_rst}), 32'h8);
        check_bits("R7 pause held", 32'(dom_en), 32'h4);
        pause = 1'b0;
        @(negedge clk);
        check_bits("R8 resume enables", 32'(dom_en), 32'h7);
        check_bits("R8 resume no reset", 32'({ready, dom_rst}), 32'h8);
    endtask

    task automatic t_shutdown(input bit with_pause);
        pause = with_pause;
        @(negedge clk);
        shutdown_req = 1'b1;
        @(negedge clk);
        shutdown_req = 1'b0;
        check_bits("R5 reset raised", 32'(dom_rst), 32'h7);
        check_bits("R5 ready dropped", 32'(ready), 32'h0);
        check_bits("R9 enables dropped", 32'(dom_en), 32'h0);
        wait_ready("R5 shutdown");
        check_bits("R9 enables after shutdown", 32'(dom_en), with_pause ? 32'h4 : 32'h7);
        check_sequence(with_pause ? "R5 shutdown paused" : "R5 shutdown");
        pause = 1'b0;
        @(negedge clk);
        check_bits("R8 enables after unpause", 32'(dom_en), 32'h7);
    endtask

    task automatic t_ignored();
        int n = 0;
        int bad = 0;
        @(negedge clk);
        shutdown_req = 1'b1;
        @(negedge clk);
        shutdown_req = 1'b0;
        while (dom_rst[0] !== 1'b0 && n < 4000) begin
            @(negedge clk);
            n++;
        end
        shutdown_req = 1'b1;
        @(negedge clk);
        shutdown_req = 1'b0;
        check_bits("R6 mid-sequence not ready", 32'(ready), 32'h0);
        wait_ready("R6 completes");
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            if (ready !== 1'b1 || dom_rst !== 3'b000) bad++;
        end
        check(bad == 0, "R6 no restart", $sformatf("%0d bad cycles", bad), "0");
        check_sequence("R6");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

    initial begin
        t_powerup();
        t_pause();
        t_shutdown(1'b0);
        t_shutdown(1'b1);
        t_ignored();
        t_pause();
        $display("test done: total=%0d bad=%0d", checks, fails);
        $finish;
    end

endmodule